// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port. Software drives pins through an output value register and a per-pin output-enable register. It reads the synchronized pad levels through a read-only register. Every pin has its own interrupt detector with four sense choices: low level, high level, rising edge or falling edge. A per-pin any-edge override fires on both transitions, so software never has to swap the sense between rising and falling after each edge.

Detected events set sticky status bits. Software clears a status bit by writing 1 to it. A per-pin mask gates the status bits into a single interrupt line. The mask does not stop a status bit from being set.

Register access uses a request channel and a response channel, each with a valid/ready handshake. A request moves when `req_valid_i` and `req_ready_o` are both high. Every accepted request, read or write, returns exactly one response beat, and a write's beat carries zero data. The response is held until `rsp_ready_i` is high. While a response is pending and not taken, `req_ready_o` stays low, so at most one response is ever outstanding. With `rsp_ready_i` held high, a new request can be accepted on every cycle.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the data, direction, both sense registers, the mask and the any-edge register read zero, and `pad_o`, `pad_oe_o` and `irq_o` are zero.
- R2: Byte offset 0x00 holds the output value and 0x04 the output enable, one bit per pin. Each reads back the last value written and drives `pad_o` and `pad_oe_o` directly.
- R3: Offset 0x08 returns the pad inputs after a two-flop synchronizer, whatever the direction setting. A read accepted at the second clock edge after a pad change still returns the old value. Writes to 0x08 are ignored.
- R4: Pin n's 2-bit sense field sits at bits [2*(n mod 16)+1 : 2*(n mod 16)]. For pins 0-15 the field is in the register at 0x0C, and for pins 16-31 it is in the register at 0x10. Both registers read back as written.
- R5: Sense code 00 flags a low level and 01 flags a high level. A level source sets its status bit on every cycle the level holds, so the bit comes back right after a clear while the level persists.
- R6: Sense code 10 flags a rising edge and 11 flags a falling edge of the synchronized pad, comparing it with its value one cycle earlier. An edge of the other direction sets nothing.
- R7: When bit n of the any-edge register (offset 0x1C) is 1, pin n flags both rising and falling edges, and its sense field is ignored.
- R8: Status bits (offset 0x18) are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. When a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is the OR over all pins of status AND mask (offset 0x14). Status bits still set while their mask bit is 0.
- R10: Each accepted request yields one response beat on the cycle after acceptance. While `rsp_valid_o` is high and `rsp_ready_i` is low, the beat and its data hold and `req_ready_o` is low.
- R11: Byte offsets at 0x20 and above read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_rdata_o | output | 32 | Read data (zero for writes) |
| pad_i | input | 32 | Pad input levels (asynchronous) |
| pad_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The detector is swept over every pin and five configurations: the four sense codes plus the any-edge override with its sense field set to low level. All other pins are left in rising-edge sense and held still, so any bit they set would show up. The same stimulus runs for each configuration: a quiet low level, then a rising step, a clear, a falling step, and a clear followed at once by a read. The status word at each step tells the level modes from the edge modes and rising from falling. It also shows that the override ignores its field and that a level event wins over a simultaneous clear. Separate patterns cover the synchronizer latency, the ignored writes, the unmapped offsets, and a response held under back-pressure.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    RI_DATA   = 3'd0,
    RI_DIR    = 3'd1,
    RI_PAD    = 3'd2,
    RI_SNS_LO = 3'd3,
    RI_SNS_HI = 3'd4,
    RI_MASK   = 3'd5,
    RI_STAT   = 3'd6,
    RI_ANYE   = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_HIGH = 2'b01,
    SNS_RISE = 2'b10,
    SNS_FALL = 2'b11
  } sense_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= pad_i;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic [1:0] sense_i,
  input  logic       any_edge_i,
  input  logic       cur_i,
  input  logic       prev_i,
  output logic       hit_o
);
  logic sense_hit;

  always_comb begin
    unique case (sense_e'(sense_i))
      SNS_LOW:  sense_hit = ~cur_i;
      SNS_HIGH: sense_hit = cur_i;
      SNS_RISE: sense_hit = cur_i & ~prev_i;
      SNS_FALL: sense_hit = ~cur_i & prev_i;
      default:  sense_hit = 1'b0;
    endcase
  end

  // the any-edge override takes precedence over the 2-bit field
  assign hit_o = any_edge_i ? (cur_i ^ prev_i) : sense_hit;
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] event_i,
  input  logic [W-1:0] clear_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clear_i) | event_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_i);

  // R8: a set bit only falls when a clear was requested for it
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(status_q) & ~$past(clear_i)) & ~status_q) == '0));

  // R8: an event always lands, even against a clear
  a_r8_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((status_q & $past(event_i)) == $past(event_i)));
endmodule

// File: rtl/gpio_reg_bus.sv
module gpio_reg_bus
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [REG_W-1:0]   req_wdata_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [REG_W-1:0]   rsp_rdata_o,
  input  logic [NPINS-1:0]   pad_sync_i,
  input  logic [NPINS-1:0]   status_i,
  output logic [NPINS-1:0]   data_o,
  output logic [NPINS-1:0]   dir_o,
  output logic [2*NPINS-1:0] sense_o,
  output logic [NPINS-1:0]   mask_o,
  output logic [NPINS-1:0]   any_edge_o,
  output logic [NPINS-1:0]   clear_o
);
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 3;
  localparam int SNS_W   = 2 * NPINS;
  localparam int SNS_PAD = 2 * REG_W;

  logic [NPINS-1:0]  data_q, dir_q, mask_q, anye_q;
  logic [SNS_W-1:0]  sense_q;
  logic              rsp_valid_q;
  logic [REG_W-1:0]  rsp_data_q;

  logic              accept, in_map, wr_hit;
  reg_idx_e          idx;
  logic [SNS_PAD-1:0] sense_wide, sense_next;
  logic [REG_W-1:0]  rdata;

  function automatic logic [REG_W-1:0] widen(input logic [NPINS-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  assign req_ready_o = ~rsp_valid_q | rsp_ready_i;
  assign accept      = req_valid_i & req_ready_o;
  assign in_map      = (req_addr_i >> (IDX_LSB + IDX_W)) == '0;
  assign idx         = reg_idx_e'(req_addr_i[IDX_LSB +: IDX_W]);
  assign wr_hit      = accept & req_write_i & in_map;

  always_comb begin
    sense_wide = '0;
    sense_wide[SNS_W-1:0] = sense_q;
    sense_next = sense_wide;
    if (wr_hit && idx == RI_SNS_LO) sense_next[REG_W-1:0]     = req_wdata_i;
    if (wr_hit && idx == RI_SNS_HI) sense_next[SNS_PAD-1:REG_W] = req_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      dir_q   <= '0;
      mask_q  <= '0;
      anye_q  <= '0;
      sense_q <= '0;
    end else if (wr_hit) begin
      unique case (idx)
        RI_DATA: data_q <= req_wdata_i[NPINS-1:0];
        RI_DIR:  dir_q  <= req_wdata_i[NPINS-1:0];
        RI_MASK: mask_q <= req_wdata_i[NPINS-1:0];
        RI_ANYE: anye_q <= req_wdata_i[NPINS-1:0];
        RI_SNS_LO, RI_SNS_HI: sense_q <= sense_next[SNS_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (in_map) begin
      unique case (idx)
        RI_DATA:   rdata = widen(data_q);
        RI_DIR:    rdata = widen(dir_q);
        RI_PAD:    rdata = widen(pad_sync_i);
        RI_SNS_LO: rdata = sense_wide[REG_W-1:0];
        RI_SNS_HI: rdata = sense_wide[SNS_PAD-1:REG_W];
        RI_MASK:   rdata = widen(mask_q);
        RI_STAT:   rdata = widen(status_i);
        RI_ANYE:   rdata = widen(anye_q);
        default:   rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= req_write_i ? '0 : rdata;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign clear_o     = (wr_hit && idx == RI_STAT) ? req_wdata_i[NPINS-1:0] : '0;
  assign data_o      = data_q;
  assign dir_o       = dir_q;
  assign sense_o     = sense_q;
  assign mask_o      = mask_q;
  assign any_edge_o  = anye_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  // R10: every accepted request produces a beat next cycle
  a_r10_one_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  // R10: a stalled beat holds its data
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [31:0]       rsp_rdata_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0]   sync_v, prev_v, status_v, clear_v, mask_v, anye_v, hit_v;
  logic [2*NPINS-1:0] sense_v;

  gpio_pad_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .pad_i (pad_i),
    .sync_o (sync_v), .prev_o (prev_v)
  );

  gpio_reg_bus #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .req_valid_i (req_valid_i), .req_ready_o (req_ready_o),
    .req_write_i (req_write_i), .req_addr_i (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o), .rsp_ready_i (rsp_ready_i),
    .rsp_rdata_o (rsp_rdata_o),
    .pad_sync_i (sync_v), .status_i (status_v),
    .data_o (pad_o), .dir_o (pad_oe_o), .sense_o (sense_v),
    .mask_o (mask_v), .any_edge_o (anye_v), .clear_o (clear_v)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    gpio_pin_detect u_det (
      .sense_i (sense_v[2*n +: 2]), .any_edge_i (anye_v[n]),
      .cur_i (sync_v[n]), .prev_i (prev_v[n]), .hit_o (hit_v[n])
    );
  end

  gpio_irq_status #(.W(NPINS)) u_stat (
    .clk_i (clk_i), .rst_ni (rst_ni), .event_i (hit_v), .clear_i (clear_v),
    .mask_i (mask_v), .status_o (status_v), .irq_o (irq_o)
  );

  // R7: any transition on an any-edge pin lands in its status bit
  a_r7_any_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((anye_v & (sync_v ^ prev_v)) != '0) |=>
      ((status_v & $past(anye_v & (sync_v ^ prev_v))) == $past(anye_v & (sync_v ^ prev_v))));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata, pad_in = '0, pad_out, pad_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_port u0 (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready), .req_write_i (req_write),
    .req_addr_i (req_addr), .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid), .rsp_ready_i (rsp_ready), .rsp_rdata_o (rsp_rdata),
    .pad_i (pad_in), .pad_o (pad_out), .pad_oe_o (pad_oe), .irq_o (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 beat", {31'd0, rsp_valid}, 32'd1);
    r = rsp_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus(1'b1, a, d, dummy);
  endtask

  // clear all status then read it in the very next cycle
  task automatic clr_then_read(output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h18; req_wdata = '1;
    @(negedge clk);
    req_write = 1'b0; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] sns;
    idle(3);
    // R1: outputs during reset
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_o", pad_out, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    rst_n = 1'b1;
    idle(2);
    bus(0, 8'h00, 0, r); chk("R1 data", r, 0);
    bus(0, 8'h04, 0, r); chk("R1 dir", r, 0);
    bus(0, 8'h0C, 0, r); chk("R1 sense lo", r, 0);
    bus(0, 8'h10, 0, r); chk("R1 sense hi", r, 0);
    bus(0, 8'h14, 0, r); chk("R1 mask", r, 0);
    bus(0, 8'h1C, 0, r); chk("R1 any-edge", r, 0);
    // R5: default low-level sense with low pads sets every status bit
    bus(0, 8'h18, 0, r); chk("R5 low level after reset", r, 32'hFFFF_FFFF);
    chk("R9 masked irq", {31'd0, irq}, 0);

    // R2
    wr(8'h00, 32'hA5A5_0F0F); wr(8'h04, 32'h0000_FFFF);
    bus(0, 8'h00, 0, r); chk("R2 data readback", r, 32'hA5A5_0F0F);
    bus(0, 8'h04, 0, r); chk("R2 dir readback", r, 32'h0000_FFFF);
    chk("R2 pad_o", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);

    // R4: sense registers read back
    wr(8'h0C, 32'h1357_9BDF); wr(8'h10, 32'hECA8_6420);
    bus(0, 8'h0C, 0, r); chk("R4 sense lo readback", r, 32'h1357_9BDF);
    bus(0, 8'h10, 0, r); chk("R4 sense hi readback", r, 32'hECA8_6420);

    // R3: synchronizer latency, direction independence, write ignored
    @(negedge clk); pad_in = 32'h1234_5678;
    bus(0, 8'h08, 0, r); chk("R3 old value at 2nd edge", r, 32'h0);
    idle(2);
    bus(0, 8'h08, 0, r); chk("R3 synced pads", r, 32'h1234_5678);
    wr(8'h08, 32'hFFFF_FFFF);
    bus(0, 8'h08, 0, r); chk("R3 pad write ignored", r, 32'h1234_5678);

    // R11
    bus(0, 8'h20, 0, r); chk("R11 unmapped read", r, 0);
    bus(0, 8'h44, 0, r); chk("R11 unmapped read", r, 0);
    wr(8'h20, 32'hFFFF_FFFF);
    bus(0, 8'h00, 0, r); chk("R11 write ignored", r, 32'hA5A5_0F0F);

    // R10: back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h04;
    @(negedge clk); req_valid = 1'b0;
    chk("R10 stalled valid", {31'd0, rsp_valid}, 1);
    chk("R10 stalled ready low", {31'd0, req_ready}, 0);
    chk("R10 stalled data", rsp_rdata, 32'h0000_FFFF);
    @(negedge clk);
    chk("R10 still held", {31'd0, rsp_valid}, 1);
    chk("R10 data held", rsp_rdata, 32'h0000_FFFF);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 beat drained", {31'd0, rsp_valid}, 0);

    // sweep: every pin x {low, high, rise, fall, any-edge}
    pad_in = '0;
    idle(4);
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic [31:0] bit_p, e;
        logic is_low, is_high, is_rise, is_fall, is_any;
        bit_p = 32'd1 << p;
        is_low = (m == 0); is_high = (m == 1); is_rise = (m == 2);
        is_fall = (m == 3); is_any = (m == 4);
        sns = {32{2'b10}};
        sns[2*p +: 2] = is_any ? 2'b00 : 2'(m);
        wr(8'h0C, sns[31:0]); wr(8'h10, sns[63:32]);
        wr(8'h1C, is_any ? bit_p : 32'h0);
        wr(8'h14, bit_p);
        // (a) quiet low level
        wr(8'h18, '1); idle(3);
        bus(0, 8'h18, 0, r); e = is_low ? bit_p : 0;
        chk("R4 R5 R7 quiet low", r, e);
        chk("R9 irq quiet low", {31'd0, irq}, {31'd0, e != 0});
        // (b) rising step
        @(negedge clk); pad_in = bit_p; idle(5);
        bus(0, 8'h18, 0, r); e = (is_low | is_high | is_rise | is_any) ? bit_p : 0;
        chk("R6 R7 after rise", r, e);
        chk("R9 irq after rise", {31'd0, irq}, {31'd0, e != 0});
        // (c) clear while high
        wr(8'h18, '1); idle(3);
        bus(0, 8'h18, 0, r); e = is_high ? bit_p : 0;
        chk("R5 R8 clear while high", r, e);
        // (d) falling step
        @(negedge clk); pad_in = '0; idle(5);
        bus(0, 8'h18, 0, r); e = (is_low | is_high | is_fall | is_any) ? bit_p : 0;
        chk("R6 R7 after fall", r, e);
        // (e) clear immediately followed by read
        clr_then_read(r); e = is_low ? bit_p : 0;
        chk("R8 event wins over clear", r, e);
        // write 0 has no effect, masking blocks irq only
        wr(8'h18, 32'h0);
        wr(8'h14, 32'h0);
        chk("R9 masked irq", {31'd0, irq}, 0);
        bus(0, 8'h18, 0, r);
        chk("R8 R9 status kept", r, e);
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule